// File: doc/BRIEF.md
# Dual-Mode Delay Setting Register

This block keeps the 8-bit code that picks a delay step and offers two ways to program it. In parallel mode the eight parallel pins either pass straight through to the code output while the enable is high, or, once the enable drops, the last value seen is held. In serial mode an 8-bit shift register is reached through a shift clock, a serial data input and a serial data output. The new code is committed to the output latch when the enable falls. The serial output can feed the serial input of a further unit, so several units form one long chain that is loaded MSB first, eight bits per unit.

All pins are sampled by one system clock `clk` with a synchronous active-high reset. The enable and the shift clock are treated as ordinary data inputs that are synchronous to `clk`, and their edges are found by comparing each sample with the one taken a cycle earlier. A serial read shifts the serial input into the register while the old bits leave, so a host that wants the code preserved has to feed the bits it reads back in before it releases the enable.

Top module: `delay_setting_reg`

## Requirements
- R1: After reset the code output `dly_code` is 0x00, the shift register holds 0x00, and `ser_dout` is 0.
- R2: With `prog_par` = 1 and `acc_en` = 1, `dly_code` equals `par_code` in the same cycle, with no clock edge in between.
- R3: With `prog_par` = 1, `dly_code` holds the `par_code` value sampled at the last `clk` edge at which `acc_en` was high, and changes of `par_code` while `acc_en` is low have no effect.
- R4: With `prog_par` = 0, `ser_dout` shows bit 7 of the shift register as soon as `acc_en` is high, before any shift clock edge. `ser_dout` is 0 whenever `acc_en` is low or `prog_par` is 1.
- R5: With `prog_par` = 0 and `acc_en` = 1, each rising edge of `shift_clk` (high at a `clk` edge after being low at the previous one) shifts the register one place toward bit 7 and takes `ser_din` into bit 0, so `ser_dout` then shows the next lower bit.
- R6: With `prog_par` = 0 and `acc_en` low, `shift_clk` edges leave the shift register and `dly_code` unchanged.
- R7: While `prog_par` = 0 and `acc_en` = 1, `dly_code` does not change, whatever happens on the serial pins.
- R8: With `prog_par` = 0, the `clk` edge that first samples `acc_en` low after it was high copies the shift register to `dly_code`. Before that edge `dly_code` still shows the old code.
- R9: A read is destructive: the bits shifted in replace the code, and shifting the read bits back in before the enable is released leaves the code unchanged. Two units chained from `ser_dout` to `ser_din` take 16 bits, with the first eight landing in the far unit.
- R10: In parallel mode the shift register is reloaded with the code in effect, so a later serial read returns that code MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_par | input | 1 | 1 selects parallel programming, 0 selects serial |
| acc_en | input | 1 | Access enable for both programming methods |
| par_code | input | 8 | Parallel code pins |
| shift_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out, bit 7 of the shift register |
| dly_code | output | 8 | Active delay-select code |

## Verification
The transparent parallel path and the serial output are combinational, so the bench checks them a moment after it changes the pins, with no clock edge in between. A shift, a latch capture or a commit takes effect at the first `clk` edge that samples the triggering level, so the bench drives pins on the falling edge of `clk` and samples on the next falling edge after that rising edge. For R8 it also samples once just before the commit edge to confirm that the old code is still there.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    localparam int SET_W = 8;

    typedef enum logic {
        PROG_SERIAL   = 1'b0,
        PROG_PARALLEL = 1'b1
    } prog_mode_e;

    typedef struct packed {
        logic par_load;
        logic shift;
        logic commit;
    } strobe_t;

    function automatic logic rising(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

    function automatic logic falling(input logic now_v, input logic prev_v);
        return ~now_v & prev_v;
    endfunction

endpackage

// File: rtl/dsr_ctrl.sv
module dsr_ctrl
    import dsr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    mode_i,
    input  logic    en_i,
    input  logic    sck_i,
    output strobe_t strb_o
);

    logic       en_q;
    logic       sck_q;
    prog_mode_e mode;

    assign mode = prog_mode_e'(mode_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            sck_q <= 1'b0;
        end else begin
            en_q  <= en_i;
            sck_q <= sck_i;
        end
    end

    always_comb begin
        strb_o = '0;
        if (mode == PROG_PARALLEL) begin
            strb_o.par_load = en_i;
        end else begin
            strb_o.shift  = en_i & rising(sck_i, sck_q);
            strb_o.commit = falling(en_i, en_q);
        end
    end

    // R5: at most one action per cycle
    p_one_action_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strb_o.par_load, strb_o.shift, strb_o.commit}));

    // R8: a commit needs the enable high one cycle earlier
    p_commit_after_en_r8: assert property (@(posedge clk) disable iff (rst)
        strb_o.commit |-> $past(en_i));

endmodule

// File: rtl/dsr_shift.sv
module dsr_shift #(
    parameter int W = dsr_pkg::SET_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         shift_i,
    input  logic         sdi_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= load_val_i;
        end else if (shift_i) begin
            q_o <= {q_o[W-2:0], sdi_i};
        end
    end

    // R5: one step toward the MSB with the serial bit entering at bit 0
    p_shift_step_r5: assert property (@(posedge clk) disable iff (rst)
        (shift_i && !load_i) |=> (q_o == {$past(q_o[W-2:0]), $past(sdi_i)}));

    // R6: no load and no shift keeps the contents
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!shift_i && !load_i) |=> $stable(q_o));

endmodule

// File: rtl/dsr_latch.sv
module dsr_latch
    import dsr_pkg::*;
#(
    parameter int W = dsr_pkg::SET_W
) (
    input  logic         clk,
    input  logic         rst,
    input  strobe_t      strb_i,
    input  logic [W-1:0] par_i,
    input  logic [W-1:0] sreg_i,
    output logic [W-1:0] act_o,
    output logic [W-1:0] act_next_o
);

    always_comb begin
        act_next_o = act_o;
        if (strb_i.par_load) begin
            act_next_o = par_i;
        end else if (strb_i.commit) begin
            act_next_o = sreg_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_o <= '0;
        end else begin
            act_o <= act_next_o;
        end
    end

    // R8: the commit copies the shift register
    p_commit_copy_r8: assert property (@(posedge clk) disable iff (rst)
        strb_i.commit |=> (act_o == $past(sreg_i)));

    // R3: without a load or commit the code holds
    p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!strb_i.par_load && !strb_i.commit) |=> $stable(act_o));

endmodule

// File: rtl/delay_setting_reg.sv
module delay_setting_reg
    import dsr_pkg::*;
#(
    parameter int W = dsr_pkg::SET_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         prog_par,
    input  logic         acc_en,
    input  logic [W-1:0] par_code,
    input  logic         shift_clk,
    input  logic         ser_din,
    output logic         ser_dout,
    output logic [W-1:0] dly_code
);

    strobe_t      strb;
    logic [W-1:0] sreg;
    logic [W-1:0] act;
    logic [W-1:0] act_next;

    dsr_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .mode_i (prog_par),
        .en_i   (acc_en),
        .sck_i  (shift_clk),
        .strb_o (strb)
    );

    dsr_latch #(.W(W)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .strb_i     (strb),
        .par_i      (par_code),
        .sreg_i     (sreg),
        .act_o      (act),
        .act_next_o (act_next)
    );

    dsr_shift #(.W(W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .load_i     (prog_par),
        .load_val_i (act_next),
        .shift_i    (strb.shift),
        .sdi_i      (ser_din),
        .q_o        (sreg)
    );

    assign dly_code = strb.par_load ? par_code : act;
    assign ser_dout = ~prog_par & acc_en & sreg[W-1];

    // R7: serial access in progress leaves the code alone
    p_serial_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (!prog_par && acc_en) |=> $stable(act));

    // R10: parallel mode mirrors the code into the shift register
    p_mirror_r10: assert property (@(posedge clk) disable iff (rst)
        prog_par |=> (sreg == act));

    // R6: enable low in serial mode freezes the shift register
    p_sck_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (!prog_par && !acc_en) |=> $stable(sreg));

endmodule

// File: tb/delay_setting_reg_bench.sv
module delay_setting_reg_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_par = 1'b0;
    logic       acc_en = 1'b0;
    logic [7:0] par_code = 8'h00;
    logic       shift_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_dout;
    logic [7:0] dly_code;
    logic       tail_dout;
    logic [7:0] tail_code;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    delay_setting_reg u_delay_setting_reg (
        .clk       (clk),
        .rst       (rst),
        .prog_par  (prog_par),
        .acc_en    (acc_en),
        .par_code  (par_code),
        .shift_clk (shift_clk),
        .ser_din   (ser_din),
        .ser_dout  (ser_dout),
        .dly_code  (dly_code)
    );

    delay_setting_reg u_tail (
        .clk       (clk),
        .rst       (rst),
        .prog_par  (prog_par),
        .acc_en    (acc_en),
        .par_code  (par_code),
        .shift_clk (shift_clk),
        .ser_din   (ser_dout),
        .ser_dout  (tail_dout),
        .dly_code  (tail_code)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    // one shift clock pulse; returns the bit seen on ser_dout before it
    task automatic pulse(input logic din, output logic seen);
        seen      = ser_dout;
        ser_din   = din;
        shift_clk = 1'b1;
        @(negedge clk);
        shift_clk = 1'b0;
        @(negedge clk);
    endtask

    // serial read of the near unit, feeding wr_val back in
    task automatic serial_pass(input logic [7:0] wr_val, output logic [7:0] rd_val);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            pulse(wr_val[i], b);
            rd_val[i] = b;
        end
    endtask

    task automatic t_reset;
        check("R1 code", dly_code, 8'h00);
        check("R1 sdo", {7'b0, ser_dout}, 8'h00);
        acc_en = 1'b1;
        #1;
        check("R1 sreg msb", {7'b0, ser_dout}, 8'h00);
        acc_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_transparent;
        prog_par = 1'b1;
        acc_en   = 1'b1;
        par_code = 8'hA5;
        #1;
        check("R2 follow A5", dly_code, 8'hA5);
        par_code = 8'h3C;
        #1;
        check("R2 follow 3C", dly_code, 8'h3C);
        check("R4 sdo low in parallel", {7'b0, ser_dout}, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_latched;
        acc_en   = 1'b0;
        par_code = 8'hFF;
        #1;
        check("R3 held at fall", dly_code, 8'h3C);
        @(negedge clk);
        par_code = 8'h11;
        @(negedge clk);
        check("R3 pins ignored", dly_code, 8'h3C);
    endtask

    task automatic t_readback;
        logic [7:0] rd;
        prog_par = 1'b0;
        @(negedge clk);
        acc_en = 1'b1;
        #1;
        check("R4 msb before clock", {7'b0, ser_dout}, 8'h00);
        serial_pass(8'h3C, rd);
        check("R10 read returns code", rd, 8'h3C);
        check("R7 code stable while shifting", dly_code, 8'h3C);
        acc_en = 1'b0;
        @(negedge clk);
        check("R9 write back keeps code", dly_code, 8'h3C);
    endtask

    task automatic t_write;
        logic [7:0] rd;
        acc_en = 1'b1;
        @(negedge clk);
        serial_pass(8'h96, rd);
        check("R5 bits out MSB first", rd, 8'h3C);
        acc_en = 1'b0;
        #1;
        check("R8 old code before commit", dly_code, 8'h3C);
        @(negedge clk);
        check("R8 new code after commit", dly_code, 8'h96);
    endtask

    task automatic t_ignore;
        logic       b;
        logic [7:0] rd;
        for (int i = 0; i < 3; i++) pulse(1'b0, b);
        check("R6 code unchanged", dly_code, 8'h96);
        acc_en = 1'b1;
        #1;
        check("R4 msb of 96", {7'b0, ser_dout}, 8'h01);
        serial_pass(8'h96, rd);
        check("R6 register unchanged", rd, 8'h96);
        acc_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_destroy;
        logic [7:0] rd;
        acc_en = 1'b1;
        @(negedge clk);
        serial_pass(8'h00, rd);
        check("R9 read value", rd, 8'h96);
        acc_en = 1'b0;
        @(negedge clk);
        check("R9 destructive read", dly_code, 8'h00);
    endtask

    task automatic t_cascade;
        logic [7:0] rd;
        acc_en = 1'b1;
        @(negedge clk);
        serial_pass(8'hC3, rd);
        serial_pass(8'h5A, rd);
        check("R9 chain near code held", dly_code, 8'h00);
        acc_en = 1'b0;
        @(negedge clk);
        check("R9 chain near unit", dly_code, 8'h5A);
        check("R9 chain far unit", tail_code, 8'hC3);
    endtask

    task automatic t_par_to_serial;
        logic [7:0] rd;
        prog_par = 1'b1;
        acc_en   = 1'b1;
        par_code = 8'h81;
        @(negedge clk);
        acc_en = 1'b0;
        @(negedge clk);
        prog_par = 1'b0;
        @(negedge clk);
        acc_en = 1'b1;
        @(negedge clk);
        serial_pass(8'h81, rd);
        check("R10 parallel then serial read", rd, 8'h81);
        acc_en = 1'b0;
        @(negedge clk);
        check("R10 code kept", dly_code, 8'h81);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_transparent();
        t_latched();
        t_readback();
        t_write();
        t_ignore();
        t_destroy();
        t_cascade();
        t_par_to_serial();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule